// File: doc/BRIEF.md
# Host Interrupt Flag Handshake

This block holds one interrupt-request flag that two agents share: a local CPU and an external host attached through a host port. The CPU raises a request by writing a word whose flag bit is 1. The block then drives an active-low interrupt line towards the host. The host acknowledges by writing a word whose flag bit is 1, which clears the flag. Both sides can read the flag back at the same bit position. A zero in that bit is a no-op for either writer.

The block also drives the ready signal of the host port. Ready drops for one cycle after each host read or write strobe and then returns high. This does not depend on the flag or on any write collision. If the CPU set and the host clear arrive in the same cycle, the set wins. The new request stays visible, the host's acknowledge counts as already applied to the older request, and the host port never hangs.

Top module: `host_irq_flag`

## Requirements
- R1: While rst_ni is low, the flag is 0, irq_no is 1 and host_rdy_o is 1.
- R2: A CPU write (cpu_wr_i=1) with bit FLAG_BIT of cpu_wdata_i at 1 makes the flag 1 from the next clock edge.
- R3: A host write (host_wr_i=1) with bit FLAG_BIT of host_wdata_i at 1 makes the flag 0 from the next clock edge, unless R5 applies.
- R4: A write from either side with bit FLAG_BIT at 0 leaves the flag unchanged, whatever the other data bits hold.
- R5: When a CPU set and a host clear occur in the same cycle, the flag is 1 after that edge.
- R6: irq_no is the inverse of the flag at all times (0 means a request is pending).
- R7: host_rdy_o is 0 in the cycle after any cycle with host_wr_i or host_rd_i at 1, and 1 in the cycle after any cycle without them, whatever the flag state or write collisions.
- R8: cpu_rdata_o and host_rdata_o carry the flag at bit FLAG_BIT and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | DATA_W | CPU write data |
| cpu_rdata_o | output | DATA_W | CPU read data, flag at FLAG_BIT |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Host read data, flag at FLAG_BIT |
| host_rdy_o | output | 1 | Host port ready, low one cycle after an access |
| irq_no | output | 1 | Interrupt to host, active low |

## Verification
The bench builds the block with DATA_W=8 and FLAG_BIT=2. Because the flag sits in a middle bit, the bench can drive 1s in the neighbouring bits with a 0 in the flag bit and show that such writes are ignored. It can also show that read data never leaks the flag into the wrong position. Random traffic with both strobes often active in the same cycle makes set/clear collisions and back-to-back host accesses frequent, and a behavioural model checks these against the expected results on every clock.

// File: rtl/hif_pkg.sv
package hif_pkg;
  typedef struct packed {
    logic cpu_set;
    logic host_clr;
  } hif_req_t;

  typedef enum logic [1:0] {
    RES_HOLD = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2
  } hif_res_e;

  // set has priority so a fresh request survives a simultaneous clear
  function automatic hif_res_e hif_resolve(hif_req_t req);
    if (req.cpu_set)       return RES_SET;
    else if (req.host_clr) return RES_CLR;
    else                   return RES_HOLD;
  endfunction
endpackage

// File: rtl/hif_decode.sv
module hif_decode
  import hif_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FLAG_BIT = 0
) (
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output hif_req_t          req_o
);
  always_comb begin
    req_o.cpu_set  = cpu_wr_i  & cpu_wdata_i[FLAG_BIT];
    req_o.host_clr = host_wr_i & host_wdata_i[FLAG_BIT];
  end
endmodule

// File: rtl/hif_flag.sv
module hif_flag
  import hif_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  hif_req_t req_i,
  output logic     flag_o
);
  hif_res_e res;
  logic     flag_q;

  assign res = hif_resolve(req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else begin
      case (res)
        RES_SET: flag_q <= 1'b1;
        RES_CLR: flag_q <= 1'b0;
        default: flag_q <= flag_q;
      endcase
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/hif_ready.sv
module hif_ready (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_wr_i,
  input  logic host_rd_i,
  output logic rdy_o
);
  logic wait_q;

  // one wait cycle per access, no dependency on flag state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= 1'b0;
    else         wait_q <= host_wr_i | host_rd_i;
  end

  assign rdy_o = ~wait_q;
endmodule

// File: rtl/host_irq_flag.sv
module host_irq_flag
  import hif_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int FLAG_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_rdy_o,
  output logic              irq_no
);
  hif_req_t req;
  logic     flag;
  logic [DATA_W-1:0] rd_word;

  hif_decode #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_decode (
    .cpu_wr_i     (cpu_wr_i),
    .cpu_wdata_i  (cpu_wdata_i),
    .host_wr_i    (host_wr_i),
    .host_wdata_i (host_wdata_i),
    .req_o        (req)
  );

  hif_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .flag_o (flag)
  );

  hif_ready u_ready (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .host_wr_i (host_wr_i),
    .host_rd_i (host_rd_i),
    .rdy_o     (host_rdy_o)
  );

  always_comb begin
    rd_word           = '0;
    rd_word[FLAG_BIT] = flag;
  end

  assign cpu_rdata_o  = rd_word;
  assign host_rdata_o = rd_word;
  assign irq_no       = ~flag;
endmodule

// File: rtl/hif_chk.sv
module hif_chk #(
  parameter int DATA_W   = 16,
  parameter int FLAG_BIT = 0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_wr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              host_wr_i,
  input logic              host_rd_i,
  input logic [DATA_W-1:0] host_wdata_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_rdy_o,
  input logic              irq_no
);
  logic set_w, clr_w, acc_w;
  assign set_w = cpu_wr_i & cpu_wdata_i[FLAG_BIT];
  assign clr_w = host_wr_i & host_wdata_i[FLAG_BIT];
  assign acc_w = host_wr_i | host_rd_i;

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_w |=> !irq_no);

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && !set_w) |=> irq_no);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_w && !clr_w) |=> $stable(irq_no));

  p_collide_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_w && clr_w) |=> !irq_no);

  p_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_rdata_o[FLAG_BIT] == !irq_no);

  p_rdy_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_w |=> !host_rdy_o);

  p_rdy_back_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_w |=> host_rdy_o);

  p_rd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rdata_o == host_rdata_o) && $countones(host_rdata_o) <= 1);
endmodule

bind host_irq_flag hif_chk #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cpu_wr_i     (cpu_wr_i),
  .cpu_wdata_i  (cpu_wdata_i),
  .cpu_rdata_o  (cpu_rdata_o),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_o (host_rdata_o),
  .host_rdy_o   (host_rdy_o),
  .irq_no       (irq_no)
);

// File: tb/tb_host_irq_flag.sv
module tb_host_irq_flag;
  localparam int DATA_W   = 8;
  localparam int FLAG_BIT = 2;
  localparam int CLK_PERIOD = 10;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cpu_wr_i = 1'b0;
  logic [DATA_W-1:0] cpu_wdata_i = '0;
  logic [DATA_W-1:0] cpu_rdata_o;
  logic              host_wr_i = 1'b0;
  logic              host_rd_i = 1'b0;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic [DATA_W-1:0] host_rdata_o;
  logic              host_rdy_o;
  logic              irq_no;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  int m_flag = 0;
  int m_rdy  = 1;
  string tag = "R1";

  host_irq_flag #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .cpu_rdata_o(cpu_rdata_o),
    .host_wr_i(host_wr_i), .host_rd_i(host_rd_i), .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o), .host_rdy_o(host_rdy_o), .irq_no(irq_no)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int rd_exp;
    rd_exp = m_flag << FLAG_BIT;
    check(tag, irq_no, m_flag ? 0 : 1);
    check("R6", irq_no, m_flag ? 0 : 1);
    check("R7", host_rdy_o, m_rdy);
    check("R8", host_rdata_o, rd_exp);
    check("R8", cpu_rdata_o, rd_exp);
  endtask

  // apply inputs, then after the edge update model and compare
  task automatic step(bit cw, int cd, bit hw, bit hr, int hd);
    bit set, clr;
    cpu_wr_i = cw; cpu_wdata_i = cd[DATA_W-1:0];
    host_wr_i = hw; host_rd_i = hr; host_wdata_i = hd[DATA_W-1:0];
    set = cw && cd[FLAG_BIT];
    clr = hw && hd[FLAG_BIT];
    if (set && clr) tag = "R5";
    else if (set)   tag = "R2";
    else if (clr)   tag = "R3";
    else            tag = "R4";
    @(negedge clk_i);
    if (set)      m_flag = 1;
    else if (clr) m_flag = 0;
    m_rdy = (hw || hr) ? 0 : 1;
    compare_all();
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    tag = "R1";
    check("R1", irq_no, 1);
    check("R1", host_rdy_o, 1);
    check("R1", host_rdata_o, 0);
    // strobes during reset must not matter
    cpu_wr_i = 1'b1; cpu_wdata_i = 8'hFF; host_rd_i = 1'b1;
    @(negedge clk_i);
    check("R1", irq_no, 1);
    check("R1", host_rdy_o, 1);
    cpu_wr_i = 1'b0; cpu_wdata_i = '0; host_rd_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);

    step(1, 8'hFB, 0, 0, 0);   // R4: neighbours set, flag bit clear
    step(1, 8'h04, 0, 0, 0);   // R2
    step(0, 0, 1, 0, 8'hFB);   // R4 from host
    step(0, 0, 0, 1, 0);       // R7 read access
    step(0, 0, 0, 0, 0);       // R7 recovery
    step(0, 0, 1, 0, 8'h04);   // R3
    step(1, 8'h04, 1, 0, 8'h04); // R5 collision while clear
    step(1, 8'h04, 1, 0, 8'h04); // R5 collision while set
    step(0, 0, 1, 1, 8'h04);   // R3 with read too
    step(0, 0, 1, 0, 8'h04);   // back-to-back host access, R7
    step(0, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom;
      step(r[0], $urandom & 8'hFF, r[1], r[2], $urandom & 8'hFF);
    end

    // assert reset mid-run
    step(1, 8'h04, 1, 0, 0);
    rst_ni = 1'b0;
    #1;
    tag = "R1";
    check("R1", irq_no, 1);
    check("R1", host_rdy_o, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule